// File: doc/BRIEF.md
# Parity Stream Router With Branch Offsets

This block takes one stream of words and splits it into two output streams by the value of each word's least significant bit. Words whose bit 0 is set leave on the odd output after a constant is added to them; words whose bit 0 is clear leave on the even output after a different constant is added. Every stream uses a valid/ready handshake. A word moves when its valid and ready are both high at a rising clock edge.

Each branch has its own small FIFO followed by a registered output stage. Because of this, a stalled consumer on one output holds back only the words bound for that output. The block has no start, done or configuration inputs. It runs continuously from reset and accepts a word in any cycle in which the branch the word selects has room. Within a branch, words leave in the order they arrived. The two branches are not ordered relative to each other.

Top module: `parity_stream_router`

## Requirements
- R1: An accepted word with bit 0 equal to 0 appears only on the even output, with value `word + EVEN_OFFSET` (default 2), taken modulo 2^DATA_W.
- R2: An accepted word with bit 0 equal to 1 appears only on the odd output, with value `word + ODD_OFFSET` (default 1), taken modulo 2^DATA_W.
- R3: Each output delivers its words in the same order in which the input accepted them. No word is lost or duplicated.
- R4: When the branch selected by the present input word is full, `in_ready` is low. With its output stalled, a branch holds exactly FIFO_DEPTH + 1 words: FIFO_DEPTH (default 5) in the FIFO and one in the output register.
- R5: While one output is stalled and its branch is full, a word that selects the other branch is still accepted, provided that branch has room, and it is delivered.
- R6: A synchronous active-high reset empties both branches. In the first cycle after reset, both output valids are low and `in_ready` is high.
- R7: While an output's valid is high and its ready is low, that output's valid and data stay unchanged.
- R8: While both output readies are held high, the input accepts one word on every cycle with no stall.
- R9: The addition wraps. With the default offsets, 0xFFFFFFFF leaves the odd output as 0x00000000 and 0xFFFFFFFE leaves the even output as 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | The branch selected by the input word can take it |
| in_data | input | DATA_W | Input word |
| odd_valid | output | 1 | Odd-branch result present |
| odd_ready | input | 1 | Consumer takes the odd-branch result |
| odd_data | output | DATA_W | Odd word plus ODD_OFFSET |
| even_valid | output | 1 | Even-branch result present |
| even_ready | input | 1 | Consumer takes the even-branch result |
| even_data | output | DATA_W | Even word plus EVEN_OFFSET |

## Verification
The embedded checks rely on three conditions: reset is asserted before the first word, `in_data` is a known value whenever `in_valid` is high, and nothing outside the block drives the FIFOs. They do not require the input to hold a word steady while it is refused. The bench drives inputs shortly after each rising edge and always applies a defined word. When a word is refused during the full-branch test, the bench drops valid, which the block must tolerate. The output readies are driven only through the ports, either held constant or toggled from a pseudo-random sequence. This keeps the handshake legal under every ready pattern.

// File: rtl/prr_pkg.sv
package prr_pkg;

  // Default word width of the streams.
  localparam int WORD_W = 32;

  // Branch index. The value equals the word's bit 0.
  typedef enum logic {
    BR_EVEN = 1'b0,
    BR_ODD  = 1'b1
  } branch_e;

  localparam int NUM_BRANCH = 2;

endpackage

// File: rtl/prr_fifo.sv
// Small synchronous FIFO. The depth need not be a power of two.
module prr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // Storage has no reset, so it can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (count == CMAX);
  assign empty    = (count == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX);

endmodule

// File: rtl/prr_branch.sv
// One branch: a FIFO followed by a registered adder stage that drives the output stream.
module prr_branch #(
  parameter int W      = 32,
  parameter int DEPTH  = 5,
  parameter int OFFSET = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam logic [W-1:0] ADD = W'(OFFSET);

  logic         fifo_pop, fifo_empty;
  logic [W-1:0] fifo_data;
  logic         valid_q;
  logic [W-1:0] data_q;

  prr_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (fifo_pop),
    .pop_data  (fifo_data),
    .full      (full),
    .empty     (fifo_empty)
  );

  // Load the output register when it is empty or is being drained.
  assign fifo_pop = !fifo_empty && (!valid_q || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (fifo_pop) begin
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fifo_pop) data_q <= fifo_data + ADD;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/prr_steer.sv
// Steers the input word to one branch by its bit 0.
module prr_steer #(
  parameter int W  = 32,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [NB-1:0] br_full,
  output logic          in_ready,
  output logic [NB-1:0] br_push
);
  import prr_pkg::*;

  branch_e sel;
  assign sel      = branch_e'(in_data[0]);
  assign in_ready = !br_full[sel];

  always_comb begin
    br_push = '0;
    br_push[sel] = in_valid && !br_full[sel];
  end

  // R1
  even_route_chk: assert property (@(posedge clk) disable iff (rst)
    br_push[BR_EVEN] |-> (!in_data[0] && !br_push[BR_ODD]));

  // R2
  odd_route_chk: assert property (@(posedge clk) disable iff (rst)
    br_push[BR_ODD] |-> (in_data[0] && !br_push[BR_EVEN]));

  // R3
  push_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(br_push));

endmodule

// File: rtl/parity_stream_router.sv
module parity_stream_router #(
  parameter int DATA_W      = prr_pkg::WORD_W,
  parameter int FIFO_DEPTH  = 5,
  parameter int ODD_OFFSET  = 1,
  parameter int EVEN_OFFSET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              odd_valid,
  input  logic              odd_ready,
  output logic [DATA_W-1:0] odd_data,
  output logic              even_valid,
  input  logic              even_ready,
  output logic [DATA_W-1:0] even_data
);
  import prr_pkg::*;
  localparam int NB = NUM_BRANCH;

  logic [NB-1:0]     br_full, br_push, br_valid, br_ready;
  logic [DATA_W-1:0] br_data [NB];

  prr_steer #(.W(DATA_W), .NB(NB)) u_steer (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .br_full  (br_full),
    .in_ready (in_ready),
    .br_push  (br_push)
  );

  for (genvar g = 0; g < NB; g++) begin : g_branch
    localparam int OFF = (g == int'(BR_ODD)) ? ODD_OFFSET : EVEN_OFFSET;
    prr_branch #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .OFFSET(OFF)) u_branch (
      .clk       (clk),
      .rst       (rst),
      .push      (br_push[g]),
      .push_data (in_data),
      .full      (br_full[g]),
      .out_valid (br_valid[g]),
      .out_data  (br_data[g]),
      .out_ready (br_ready[g])
    );
  end

  assign br_ready[BR_ODD]  = odd_ready;
  assign br_ready[BR_EVEN] = even_ready;
  assign odd_valid  = br_valid[BR_ODD];
  assign odd_data   = br_data[BR_ODD];
  assign even_valid = br_valid[BR_EVEN];
  assign even_data  = br_data[BR_EVEN];

  // R6
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!odd_valid && !even_valid && in_ready));

endmodule

// File: tb/parity_stream_router_tb.sv
module parity_stream_router_tb;
  localparam int W = 32;
  localparam int DEPTH = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic odd_ready = 1'b1, even_ready = 1'b1;
  logic in_ready, odd_valid, even_valid;
  logic [W-1:0] odd_data, even_data;

  int checks = 0;
  int errors = 0;
  int stalls = 0;
  bit rnd_mode = 1'b0;
  bit mon_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [W-1:0] q_odd[$];
  logic [W-1:0] q_even[$];

  always #10 clk = ~clk;

  parity_stream_router u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .odd_valid(odd_valid), .odd_ready(odd_ready), .odd_data(odd_data),
    .even_valid(even_valid), .even_ready(even_ready), .even_data(even_data)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Holds a word until it is accepted. Called at posedge + 2.
  task automatic send(input logic [W-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  // Offers a word for one cycle only.
  task automatic try_send(input logic [W-1:0] d, output bit acc);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    acc = in_ready;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      if (q_odd.size() == 0 && q_even.size() == 0) break;
      @(posedge clk);
    end
    #2;
  endtask

  // Pseudo-random ready pattern.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rnd_mode) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        odd_ready  = lfsr[0];
        even_ready = lfsr[5] | lfsr[9];
      end
    end
  end

  // Monitor: the reference model and the output comparison, sampled at the falling edge.
  logic         odd_stall_p = 1'b0, even_stall_p = 1'b0;
  logic [W-1:0] odd_hold_p, even_hold_p;
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (odd_stall_p)
        check(odd_valid && odd_data == odd_hold_p, "R7 odd hold", odd_data, odd_hold_p);
      if (even_stall_p)
        check(even_valid && even_data == even_hold_p, "R7 even hold", even_data, even_hold_p);
      if (in_valid && in_ready) begin
        if (in_data[0]) q_odd.push_back(in_data + 32'd1);
        else            q_even.push_back(in_data + 32'd2);
      end
      if (odd_valid && odd_ready) begin
        if (q_odd.size() == 0) check(1'b0, "R2/R3 odd extra word", odd_data, '0);
        else begin
          logic [W-1:0] e;
          e = q_odd.pop_front();
          check(odd_data == e, "R2/R3 odd value", odd_data, e);
        end
      end
      if (even_valid && even_ready) begin
        if (q_even.size() == 0) check(1'b0, "R1/R3 even extra word", even_data, '0);
        else begin
          logic [W-1:0] e;
          e = q_even.pop_front();
          check(even_data == e, "R1/R3 even value", even_data, e);
        end
      end
      odd_stall_p  = odd_valid && !odd_ready;
      even_stall_p = even_valid && !even_ready;
      odd_hold_p   = odd_data;
      even_hold_p  = even_data;
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    report();
    $finish;
  end

  initial begin
    bit acc;
    int n_acc;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    // R6
    check(!odd_valid && !even_valid, "R6 valids after reset", {30'd0, odd_valid, even_valid}, '0);
    check(in_ready, "R6 in_ready after reset", {31'd0, in_ready}, 32'd1);
    mon_on = 1'b1;
    @(posedge clk);
    #2;

    // R8 full-rate sweep over small values with both outputs ready
    stalls = 0;
    for (int i = 0; i < 256; i++) send(32'(i));
    for (int i = 0; i < 64; i++) send(32'h8000_0000 + 32'(i * 977));
    check(stalls == 0, "R8 no stall at full rate", 32'(stalls), 32'd0);
    drain();

    // R9 wraparound
    send(32'hFFFF_FFFF);
    send(32'hFFFF_FFFE);
    send(32'hFFFF_FFFD);
    drain();
    check(q_odd.size() == 0 && q_even.size() == 0, "R9 wrap words delivered", 32'(q_odd.size() + q_even.size()), '0);

    // R4 capacity with odd output stalled
    odd_ready = 1'b0;
    n_acc = 0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      try_send(32'(2 * k + 101), acc);
      if (acc) n_acc++;
    end
    check(n_acc == DEPTH + 1, "R4 odd branch capacity", 32'(n_acc), 32'(DEPTH + 1));
    @(negedge clk);
    in_data = 32'd7;
    check(!in_ready, "R4 ready low for full branch", {31'd0, in_ready}, 32'd0);
    @(posedge clk);
    #2;
    // R5 even words still pass
    for (int k = 0; k < 4; k++) begin
      try_send(32'(40 + 2 * k), acc);
      check(acc, "R5 even accepted while odd full", {31'd0, acc}, 32'd1);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q_even.size() == 0, "R5 even words delivered", 32'(q_even.size()), '0);
    check(odd_valid && odd_data == 32'd102, "R7 stalled odd head", odd_data, 32'd102);
    @(posedge clk);
    #2;
    odd_ready = 1'b1;
    drain();

    // R4 capacity with even output stalled
    even_ready = 1'b0;
    n_acc = 0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      try_send(32'(2 * k), acc);
      if (acc) n_acc++;
    end
    check(n_acc == DEPTH + 1, "R4 even branch capacity", 32'(n_acc), 32'(DEPTH + 1));
    try_send(32'd555, acc);
    check(acc, "R5 odd accepted while even full", {31'd0, acc}, 32'd1);
    even_ready = 1'b1;
    drain();

    // R3 mixed traffic with random readies
    rnd_mode = 1'b1;
    for (int i = 0; i < 600; i++) send(32'(i) * 32'h9E37_79B9);
    rnd_mode = 1'b0;
    @(posedge clk);
    #2;
    odd_ready = 1'b1;
    even_ready = 1'b1;
    drain();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(q_odd.size() == 0, "R3 odd queue empty at end", 32'(q_odd.size()), '0);
    check(q_even.size() == 0, "R3 even queue empty at end", 32'(q_even.size()), '0);
    check(!odd_valid && !even_valid, "R3 no spare output", {30'd0, odd_valid, even_valid}, '0);

    report();
    $finish;
  end

endmodule